// File: doc/BRIEF.md
# Dual-Rail Power-On Reset Sequencer

This block turns two synchronised "rail good" levels, one for an always-on standby supply and one for the main supply, into two active-low open-drain reset outputs. Each output is presented as a pull-down enable: a 1 means the pad is driven low and the reset is asserted. A reset is held for a fixed stretch of clock ticks after its rail becomes good. The stretch is a parameter; at a 50 MHz clock the default of 9,000,000 ticks gives 180 ms, inside the 140 to 240 ms window.

The main reset is sequenced behind the standby reset. If the standby rail is already good when the main rail comes up, or comes up in the same cycle, the main reset stays low until a full stretch has elapsed both from the main rail going good and from the standby reset's release. If the main rail comes up first, the main reset times out on its own.

The main reset pad also serves as an input. While the block is not pulling that pad low, a low level on it comes from outside. The block reports that as an internal reset request for as long as the pad stays low.

Top module: `dual_rail_por_seq`

## Requirements
- R1: While `rstN` is low, `stbyRstOe` and `mainRstOe` are 1 and `extRstReq` is 0.
- R2: `stbyRstOe` is 1 whenever `stbyGood` is 0. After `stbyGood` rises, `stbyRstOe` falls on the STRETCH_TICKS-th rising clock edge, provided `stbyGood` has stayed high.
- R3: If `stbyGood` is 0 in the cycle where `mainGood` rises, `mainRstOe` falls on the STRETCH_TICKS-th edge after that rise, whatever the standby rail does.
- R4: If `stbyGood` is 1 in the cycle where `mainGood` rises, `mainRstOe` falls STRETCH_TICKS edges after the later of two events: the main rise, or the edge where `stbyRstOe` fell.
- R5: When a rail's good input goes low, its enable goes to 1 in the same cycle, with no clock edge needed. The count restarts, so after the rail returns a full STRETCH_TICKS is needed again.
- R6: In the sequenced case of R4, a drop of `stbyGood` while `mainGood` stays high asserts `mainRstOe` in the same cycle. The main release then again follows R4, counted from the new standby release.
- R7: While `mainRstOe` is 0, a low on `mainPinIn` sets `extRstReq` to 1 at the next edge, and it stays 1 while the pad is low. It returns to 0 at the first edge after the pad goes high.
- R8: While `mainRstOe` is 1, the level of `mainPinIn` has no effect, and `extRstReq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset of the sequencer state |
| stbyGood | input | 1 | Standby rail above threshold (synchronised level) |
| mainGood | input | 1 | Main rail above threshold (synchronised level) |
| mainPinIn | input | 1 | Sensed level of the main reset pad |
| stbyRstOe | output | 1 | Pull-down enable of the standby reset pad (1 = reset asserted) |
| mainRstOe | output | 1 | Pull-down enable of the main reset pad (1 = reset asserted) |
| extRstReq | output | 1 | External low detected on the main reset pad |

## Verification
Two events can fall in the same cycle. The first is the decision whether the main rail is sequenced, which is taken when the main rail rises and the standby rail also rises in that cycle. The second is the main rail going good in exactly the cycle in which the standby reset is released. Both cases are driven on purpose: the rails are raised together, and the main rail is raised exactly STRETCH_TICKS cycles after the standby rail. In each case the main release must come one full stretch after the standby release, neither earlier nor later. A scoreboard holds the expected release cycle of every falling enable, so an early, late or unexpected release is reported.

// File: rtl/dual_rail_por_pkg.sv
package dual_rail_por_pkg;
  localparam int NUM_RAILS = 2;
  localparam int RAIL_STBY = 0;
  localparam int RAIL_MAIN = 1;

  // Strobes from control to the stretch-timer datapath: a rail's timer
  // counts while its enable is high and is cleared while it is low.
  typedef struct packed {
    logic mainEn;
    logic stbyEn;
  } seqStrobes_t;
endpackage

// File: rtl/dual_rail_por_timer.sv
module dual_rail_por_timer #(
  parameter int unsigned STRETCH_TICKS = 9000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(STRETCH_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STRETCH_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_rail_por_dp.sv
module dual_rail_por_dp
  import dual_rail_por_pkg::*;
#(
  parameter int unsigned STRETCH_TICKS = 9000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strobes,
  output logic        stbyDone,
  output logic        mainDone
);
  logic [NUM_RAILS-1:0] enVec;
  logic [NUM_RAILS-1:0] doneVec;

  assign enVec[RAIL_STBY] = strobes.stbyEn;
  assign enVec[RAIL_MAIN] = strobes.mainEn;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : gRail
    dual_rail_por_timer #(.STRETCH_TICKS(STRETCH_TICKS)) timerI (
      .clk  (clk),
      .rstN (rstN),
      .en   (enVec[g]),
      .done (doneVec[g])
    );
  end

  assign stbyDone = doneVec[RAIL_STBY];
  assign mainDone = doneVec[RAIL_MAIN];
endmodule

// File: rtl/dual_rail_por_ctrl.sv
module dual_rail_por_ctrl
  import dual_rail_por_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stbyGood,
  input  logic        mainGood,
  input  logic        mainPinIn,
  input  logic        stbyDone,
  input  logic        mainDone,
  output seqStrobes_t strobes,
  output logic        stbyRstOe,
  output logic        mainRstOe,
  output logic        extRstReq
);
  logic mainPrev;
  logic chainReg;
  logic chainNow;
  logic stbyReleased;

  // The sequencing choice is made in the cycle the main rail rises and
  // is then held for as long as the main rail stays good.
  assign chainNow     = mainPrev ? chainReg : stbyGood;
  assign stbyReleased = stbyGood && stbyDone;

  always_comb begin
    strobes        = '0;
    strobes.stbyEn = stbyGood;
    strobes.mainEn = mainGood && (!chainNow || stbyReleased);
  end

  assign stbyRstOe = !stbyReleased;
  assign mainRstOe = !(strobes.mainEn && mainDone);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainPrev  <= 1'b0;
      chainReg  <= 1'b0;
      extRstReq <= 1'b0;
    end else begin
      mainPrev  <= mainGood;
      chainReg  <= mainGood ? chainNow : 1'b0;
      // The pad is read only while the block itself leaves it released.
      extRstReq <= !mainRstOe && !mainPinIn;
    end
  end
endmodule

// File: rtl/dual_rail_por_seq.sv
module dual_rail_por_seq
  import dual_rail_por_pkg::*;
#(
  parameter int unsigned STRETCH_TICKS = 9000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic stbyGood,
  input  logic mainGood,
  input  logic mainPinIn,
  output logic stbyRstOe,
  output logic mainRstOe,
  output logic extRstReq
);
  seqStrobes_t strobes;
  logic        stbyDone;
  logic        mainDone;

  dual_rail_por_ctrl ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .stbyGood  (stbyGood),
    .mainGood  (mainGood),
    .mainPinIn (mainPinIn),
    .stbyDone  (stbyDone),
    .mainDone  (mainDone),
    .strobes   (strobes),
    .stbyRstOe (stbyRstOe),
    .mainRstOe (mainRstOe),
    .extRstReq (extRstReq)
  );

  dual_rail_por_dp #(.STRETCH_TICKS(STRETCH_TICKS)) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .stbyDone (stbyDone),
    .mainDone (mainDone)
  );
endmodule

// File: rtl/dual_rail_por_chk.sv
module dual_rail_por_chk #(
  parameter int unsigned STRETCH_TICKS = 9000000
) (
  input logic clk,
  input logic rstN,
  input logic stbyGood,
  input logic mainGood,
  input logic mainPinIn,
  input logic stbyRstOe,
  input logic mainRstOe,
  input logic extRstReq
);
  localparam int CW = $clog2(STRETCH_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(STRETCH_TICKS);

  // Consecutive good cycles of the standby rail, saturating at the stretch.
  logic [CW-1:0] stbyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stbyRun <= '0;
    else if (!stbyGood)      stbyRun <= '0;
    else if (stbyRun != FULL) stbyRun <= stbyRun + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_state: assert (stbyRstOe && mainRstOe && !extRstReq)
        else $error("R1 outputs not in reset state");
    end
  end

  a_r2_stby_held: assert property (@(posedge clk) disable iff (!rstN)
    !stbyGood |-> stbyRstOe);

  a_r2_stby_window: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stbyRstOe) |-> (stbyRun >= FULL));

  a_r5_main_held: assert property (@(posedge clk) disable iff (!rstN)
    !mainGood |-> mainRstOe);

  a_r3_main_release_good: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mainRstOe) |-> $past(mainGood));

  a_r7_ext_from_pin: assert property (@(posedge clk) disable iff (!rstN)
    extRstReq |-> !$past(mainPinIn));

  a_r8_ext_ignored: assert property (@(posedge clk) disable iff (!rstN)
    $past(mainRstOe) |-> !extRstReq);
endmodule

bind dual_rail_por_seq dual_rail_por_chk #(.STRETCH_TICKS(STRETCH_TICKS)) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .stbyGood  (stbyGood),
  .mainGood  (mainGood),
  .mainPinIn (mainPinIn),
  .stbyRstOe (stbyRstOe),
  .mainRstOe (mainRstOe),
  .extRstReq (extRstReq)
);

// File: tb/dual_rail_por_seq_test.sv
`timescale 1ns/1ps
module dual_rail_por_seq_test;
  localparam int S = 16;

  logic clk = 1'b0;
  logic rstN;
  logic stbyGood;
  logic mainGood;
  logic extPull;
  logic mainPinIn;
  logic stbyRstOe;
  logic mainRstOe;
  logic extRstReq;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int    rail;
    int    when;
    string tag;
  } expItem_t;
  expItem_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Open-drain pad: low if the block pulls it or something outside does.
  assign mainPinIn = !(mainRstOe || extPull);

  dual_rail_por_seq #(.STRETCH_TICKS(S)) uut (
    .clk       (clk),
    .rstN      (rstN),
    .stbyGood  (stbyGood),
    .mainGood  (mainGood),
    .mainPinIn (mainPinIn),
    .stbyRstOe (stbyRstOe),
    .mainRstOe (mainRstOe),
    .extRstReq (extRstReq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic expectFall(input int rail, input int when, input string tag);
    expItem_t it;
    it.rail = rail; it.when = when; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (q.size() != 0) @(negedge clk);
    ticks(3);
  endtask

  task automatic dropBoth(input string tag);
    stbyGood = 1'b0;
    mainGood = 1'b0;
    #1;
    check({tag, " stby asserts at once"}, stbyRstOe, 1'b1);
    check({tag, " main asserts at once"}, mainRstOe, 1'b1);
    ticks(2);
  endtask

  // Monitor: every falling enable must match the head of the queue.
  logic prevStby = 1'b1;
  logic prevMain = 1'b1;
  always @(negedge clk) begin
    #1;
    for (int r = 0; r < 2; r++) begin
      logic nowV;
      logic prevV;
      nowV  = (r == 0) ? stbyRstOe : mainRstOe;
      prevV = (r == 0) ? prevStby : prevMain;
      if (rstN && prevV && !nowV) begin
        checks++;
        if (q.size() == 0) begin
          failures++;
          $display("FAIL unexpected release rail=%0d actual=%0d expected=none", r, cyc);
        end else begin
          expItem_t it;
          it = q.pop_front();
          if (it.rail != r || it.when != cyc) begin
            failures++;
            $display("FAIL %s actual=rail%0d@%0d expected=rail%0d@%0d",
                     it.tag, r, cyc, it.rail, it.when);
          end
        end
      end
    end
    prevStby = stbyRstOe;
    prevMain = mainRstOe;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    rstN = 1'b0;
    stbyGood = 1'b0;
    mainGood = 1'b0;
    extPull = 1'b0;
    ticks(4);
    check("R1 stby in reset", stbyRstOe, 1'b1);
    check("R1 main in reset", mainRstOe, 1'b1);
    check("R1 ext in reset", extRstReq, 1'b0);
    rstN = 1'b1;
    ticks(2);

    // Standby first by 5 cycles: sequenced main (R2, R4).
    c = cyc; stbyGood = 1'b1; expectFall(0, c + S, "R2 stby first");
    ticks(5); mainGood = 1'b1; expectFall(1, c + 2*S, "R4 stby first");
    waitIdle(); dropBoth("R5");

    // Both together: decision taken in the same cycle (R4).
    c = cyc; stbyGood = 1'b1; mainGood = 1'b1;
    expectFall(0, c + S, "R2 together"); expectFall(1, c + 2*S, "R4 together");
    waitIdle(); dropBoth("R5");

    // Main first: independent timing (R3).
    c = cyc; mainGood = 1'b1; expectFall(1, c + S, "R3 main first");
    ticks(4); stbyGood = 1'b1; expectFall(0, c + 4 + S, "R2 late stby");
    waitIdle(); dropBoth("R5");

    // Main rises in the very cycle the standby reset is released (R4).
    c = cyc; stbyGood = 1'b1; expectFall(0, c + S, "R2 boundary");
    ticks(S); mainGood = 1'b1; expectFall(1, c + 2*S, "R4 same-cycle release");
    waitIdle(); dropBoth("R5");

    // Standby long released before main rises (R4).
    c = cyc; stbyGood = 1'b1; expectFall(0, c + S, "R2 early stby");
    ticks(S + 10); mainGood = 1'b1; expectFall(1, c + 2*S + 10, "R4 late main");
    waitIdle(); dropBoth("R5");

    // Glitch mid-count restarts the stretch (R5).
    stbyGood = 1'b1; ticks(5); stbyGood = 1'b0; #1;
    check("R5 stby after glitch", stbyRstOe, 1'b1);
    ticks(3);
    c = cyc; stbyGood = 1'b1; expectFall(0, c + S, "R5 restarted stretch");
    waitIdle();

    // Sequenced main follows a standby drop (R6).
    c = cyc; mainGood = 1'b1; expectFall(1, c + S, "R4 main after stby");
    waitIdle();
    stbyGood = 1'b0; #1;
    check("R6 main reasserts with stby", mainRstOe, 1'b1);
    ticks(2);
    c = cyc; stbyGood = 1'b1;
    expectFall(0, c + S, "R6 stby again"); expectFall(1, c + 2*S, "R6 main again");
    waitIdle();

    // External low on the pad while released (R7).
    extPull = 1'b1; ticks(1);
    check("R7 ext after one edge", extRstReq, 1'b1);
    ticks(3);
    check("R7 ext held", extRstReq, 1'b1);
    check("R7 block not driving", mainRstOe, 1'b0);
    extPull = 1'b0; ticks(1);
    check("R7 ext cleared", extRstReq, 1'b0);

    // Pad low while the block drives it is ignored (R8).
    mainGood = 1'b0; extPull = 1'b1; ticks(4);
    check("R8 ext ignored while driving", extRstReq, 1'b0);
    extPull = 1'b0; ticks(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule